// File: doc/BRIEF.md
# Processor Bus Memory Subsystem

This block sits on the demultiplexed side of an 8-bit processor bus and serves two on-chip memories. One is a 2 kB read/write RAM and the other is a 1 kB read-only store. The block turns the raw cycle-type, read and write strobes into four active-low strobes: memory read, memory write, I/O read and I/O write. Only the two memory strobes reach the arrays.

Each memory has a fixed address window, and the block decodes an active-low chip select for it from the upper address bits. The lower address bits index into the selected array. A shared 8-bit read-data output carries the byte of whichever memory is both selected and read-enabled. A valid flag goes high whenever that output holds real data. Addresses outside both windows, I/O cycles and malformed strobe combinations leave both memories untouched and return the idle bus value.

Top module: `mbus_mem_top`

## Requirements
- R1: With `io_m_i` low, `rd_ni` low and `wr_ni` high, only `mem_rd_no` is low. With `io_m_i` low, `rd_ni` high and `wr_ni` low, only `mem_wr_no` is low. With `io_m_i` high, the same two patterns drive only `io_rd_no` low or only `io_wr_no` low.
- R2: When `rd_ni` and `wr_ni` are both low or both high, all four strobes stay high, and no memory is written or read.
- R3: `ram_cs_no` is low exactly when address bits 15:11 are all zero (window 0000h–07FFh).
- R4: `rom_cs_no` is low exactly when bits 15:14 are 00, bits 13:12 are 11 and bits 11:10 are 00 (window 3000h–33FFh). The two chip selects are never low together.
- R5: On a rising clock edge with `ram_cs_no` low and `mem_wr_no` low, the RAM stores `wr_data_i` at index A10–A0. A later memory read at that address returns the stored byte.
- R6: The ROM byte at index n (A9–A0) equals A5h XOR n[7:0] XOR (n[9:8] placed in bits 7:6).
- R7: A memory-write cycle inside the ROM window leaves the ROM contents unchanged.
- R8: When `mem_rd_no` is low and one chip select is low, `rd_valid_o` is high and `rd_data_o` carries that memory's byte. Otherwise `rd_valid_o` is low and `rd_data_o` is 00h.
- R9: An I/O cycle never reads or writes either memory, even when its address lies inside a memory window.
- R10: A write to an unmapped address (0800h–2FFFh or 3400h–FFFFh) changes no RAM location, and a read there returns 00h with `rd_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; RAM writes occur on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Byte address |
| wr_data_i | input | 8 | Write data |
| io_m_i | input | 1 | Cycle type: high selects I/O, low selects memory |
| rd_ni | input | 1 | Raw read strobe, active low |
| wr_ni | input | 1 | Raw write strobe, active low |
| io_rd_no | output | 1 | Decoded I/O read strobe, active low |
| io_wr_no | output | 1 | Decoded I/O write strobe, active low |
| mem_rd_no | output | 1 | Decoded memory read strobe, active low |
| mem_wr_no | output | 1 | Decoded memory write strobe, active low |
| ram_cs_no | output | 1 | RAM chip select, active low |
| rom_cs_no | output | 1 | ROM chip select, active low |
| rd_data_o | output | 8 | Read data, 00h when idle |
| rd_valid_o | output | 1 | High when rd_data_o carries memory data |

## Verification
The bench uses the default parameters: a 16-bit address, an 11-bit RAM index based at 0000h, a 10-bit ROM index based at 3000h and a fill seed of A5h. With these values, every window edge can be addressed directly: 07FFh/0800h, 2FFFh/3000h, 33FFh/3400h and FFFFh. The gap addresses that would alias onto RAM index 0 under a broken decode can also be reached. Because the ROM fill is a closed formula, any ROM byte can be predicted, including those at the top and bottom of the window.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic io_rd_n;
    logic io_wr_n;
    logic mem_rd_n;
    logic mem_wr_n;
  } strobe_t;

  // ROM fill: seed ^ low byte ^ bits 9:8 folded into the top of the byte
  function automatic logic [BYTE_W-1:0] rom_fill(input logic [BYTE_W-1:0] seed,
                                                 input logic [15:0] n);
    return seed ^ n[7:0] ^ {n[9:8], n[15:10]};
  endfunction
endpackage

// File: rtl/mbus_strobe_dec.sv
module mbus_strobe_dec
  import mbus_pkg::*;
(
  input  logic    io_m_i,
  input  logic    rd_ni,
  input  logic    wr_ni,
  output strobe_t strobe_o
);
  localparam int SEL_W = 3;
  localparam int LINES = 1 << SEL_W;

  logic [SEL_W-1:0] sel;
  logic [LINES-1:0] line_n;

  assign sel = {io_m_i, rd_ni, wr_ni};

  // 3-to-8 active-low decode
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign line_n[k] = (sel != SEL_W'(k));
  end

  assign strobe_o.mem_rd_n = line_n[3'b001];
  assign strobe_o.mem_wr_n = line_n[3'b010];
  assign strobe_o.io_rd_n  = line_n[3'b101];
  assign strobe_o.io_wr_n  = line_n[3'b110];

  logic unused_lines;
  assign unused_lines = ^{line_n[0], line_n[3], line_n[4], line_n[7]};
endmodule

// File: rtl/mbus_win_dec.sv
module mbus_win_dec #(
  parameter int              ADDR_W = 16,
  parameter int              IDX_W  = 11,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cs_no,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [TAG_W-1:0] TAG = BASE[ADDR_W-1:IDX_W];

  assign cs_no = (addr_i[ADDR_W-1:IDX_W] != TAG);
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int IDX_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (!cs_ni && !we_ni) mem[idx_i] <= wdata_i;
  end

  assign drive_o = !cs_ni && !oe_ni;
  assign rdata_o = drive_o ? mem[idx_i] : '0;

  // R5: a captured byte is what the array holds afterwards at that index
  p_ram_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !we_ni) |=> (idx_i != $past(idx_i)) || (mem[idx_i] == $past(wdata_i)));
endmodule

// File: rtl/mbus_rom.sv
module mbus_rom
  import mbus_pkg::*;
#(
  parameter int              IDX_W = 10,
  parameter logic [BYTE_W-1:0] SEED = 8'hA5
) (
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              drive_o
);
  assign drive_o = !cs_ni && !oe_ni;
  assign rdata_o = drive_o ? rom_fill(SEED, 16'(idx_i)) : '0;
endmodule

// File: rtl/mbus_mem_top.sv
module mbus_mem_top
  import mbus_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              RAM_IDX_W = 11,
  parameter int              ROM_IDX_W = 10,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h0000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h3000,
  parameter logic [BYTE_W-1:0] ROM_SEED = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              io_m_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              ram_cs_no,
  output logic              rom_cs_no,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  strobe_t              strb;
  logic [RAM_IDX_W-1:0] ram_idx;
  logic [ROM_IDX_W-1:0] rom_idx;
  logic [BYTE_W-1:0]    ram_rdata, rom_rdata;
  logic                 ram_drive, rom_drive;

  mbus_strobe_dec u_strobe (
    .io_m_i  (io_m_i),
    .rd_ni   (rd_ni),
    .wr_ni   (wr_ni),
    .strobe_o(strb)
  );

  assign io_rd_no  = strb.io_rd_n;
  assign io_wr_no  = strb.io_wr_n;
  assign mem_rd_no = strb.mem_rd_n;
  assign mem_wr_no = strb.mem_wr_n;

  mbus_win_dec #(.ADDR_W(ADDR_W), .IDX_W(RAM_IDX_W), .BASE(RAM_BASE)) u_ram_win (
    .addr_i(addr_i),
    .cs_no (ram_cs_no),
    .idx_o (ram_idx)
  );

  mbus_win_dec #(.ADDR_W(ADDR_W), .IDX_W(ROM_IDX_W), .BASE(ROM_BASE)) u_rom_win (
    .addr_i(addr_i),
    .cs_no (rom_cs_no),
    .idx_o (rom_idx)
  );

  mbus_ram #(.IDX_W(RAM_IDX_W), .DATA_W(BYTE_W)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (ram_cs_no),
    .oe_ni  (strb.mem_rd_n),
    .we_ni  (strb.mem_wr_n),
    .idx_i  (ram_idx),
    .wdata_i(wr_data_i),
    .rdata_o(ram_rdata),
    .drive_o(ram_drive)
  );

  // ROM has no write input: only the read strobe reaches it
  mbus_rom #(.IDX_W(ROM_IDX_W), .SEED(ROM_SEED)) u_rom (
    .cs_ni  (rom_cs_no),
    .oe_ni  (strb.mem_rd_n),
    .idx_i  (rom_idx),
    .rdata_o(rom_rdata),
    .drive_o(rom_drive)
  );

  assign rd_data_o  = ram_rdata | rom_rdata;
  assign rd_valid_o = ram_drive | rom_drive;

  // R9: an I/O cycle never raises a memory strobe
  p_io_no_mem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_m_i |-> (mem_rd_no && mem_wr_no));

  // R2: malformed or idle strobe pairs decode to nothing
  p_bad_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni == wr_ni) |-> (io_rd_no && io_wr_no && mem_rd_no && mem_wr_no));

  // R4: windows never overlap
  p_cs_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_cs_no && !rom_cs_no));

  // R8: idle bus reads as zero, and valid data needs a read strobe and a select
  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_data_o == '0));
  p_valid_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!mem_rd_no && $countones({ram_cs_no, rom_cs_no}) == 1));

  // R1: at most one decoded strobe low at a time
  p_one_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{io_rd_no, io_wr_no, mem_rd_no, mem_wr_no}));
endmodule

// File: tb/mbus_mem_top_tb_top.sv
module mbus_mem_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        io_m = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        io_rd_n, io_wr_n, mem_rd_n, mem_wr_n, ram_cs_n, rom_cs_n;
  logic [7:0]  rdata;
  logic        rvalid;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mbus_mem_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_data_i(wdata),
    .io_m_i(io_m), .rd_ni(rd_n), .wr_ni(wr_n),
    .io_rd_no(io_rd_n), .io_wr_no(io_wr_n), .mem_rd_no(mem_rd_n), .mem_wr_no(mem_wr_n),
    .ram_cs_no(ram_cs_n), .rom_cs_no(rom_cs_n), .rd_data_o(rdata), .rd_valid_o(rvalid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_exp(input logic [15:0] a);
    logic [9:0] n;
    n = a[9:0];
    return 8'hA5 ^ n[7:0] ^ {n[9:8], 6'b0};
  endfunction

  task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d, input logic io);
    @(negedge clk);
    addr = a; wdata = d; io_m = io; rd_n = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; io_m = 1'b0;
  endtask

  task automatic rd_cycle(input logic [15:0] a, input logic io,
                          output logic [7:0] d, output logic v);
    @(negedge clk);
    addr = a; io_m = io; rd_n = 1'b0; wr_n = 1'b1;
    #1;
    d = rdata; v = rvalid;
    @(negedge clk);
    rd_n = 1'b1; io_m = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R2 idle strobes", {12'b0, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n}, 16'h000F);
    check("R8 idle valid", {15'b0, rvalid}, 16'h0);
    check("R8 idle data", {8'b0, rdata}, 16'h0);
  endtask

  task automatic t_strobes;
    // {io,rd,wr} -> expected {io_rd,io_wr,mem_rd,mem_wr}
    logic [3:0] exp [8];
    exp[0] = 4'hF; exp[1] = 4'b1101; exp[2] = 4'b1110; exp[3] = 4'hF;
    exp[4] = 4'hF; exp[5] = 4'b0111; exp[6] = 4'b1011; exp[7] = 4'hF;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      addr = 16'h0800; {io_m, rd_n, wr_n} = 3'(k);
      #1;
      check((k == 0 || k == 3 || k == 4 || k == 7) ? "R2 strobe pair" : "R1 strobe decode",
            {12'b0, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n}, {12'b0, exp[k]});
    end
    @(negedge clk);
    io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic t_chip_sel;
    logic [15:0] a [10];
    logic [1:0]  e [10];  // {ram_cs_n, rom_cs_n}
    a[0] = 16'h0000; e[0] = 2'b01;
    a[1] = 16'h07FF; e[1] = 2'b01;
    a[2] = 16'h0800; e[2] = 2'b11;
    a[3] = 16'h2FFF; e[3] = 2'b11;
    a[4] = 16'h3000; e[4] = 2'b10;
    a[5] = 16'h33FF; e[5] = 2'b10;
    a[6] = 16'h3400; e[6] = 2'b11;
    a[7] = 16'hFFFF; e[7] = 2'b11;
    a[8] = 16'h3800; e[8] = 2'b11;
    a[9] = 16'hB000; e[9] = 2'b11;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      addr = a[k];
      #1;
      check(e[k][1] ? "R3/R4 select" : "R3 ram select", {14'b0, ram_cs_n, rom_cs_n}, {14'b0, e[k]});
    end
  endtask

  task automatic t_ram_rw;
    logic [7:0] d; logic v;
    wr_cycle(16'h0000, 8'h11, 1'b0);
    wr_cycle(16'h07FF, 8'hEE, 1'b0);
    wr_cycle(16'h0123, 8'h5A, 1'b0);
    wr_cycle(16'h0400, 8'hC3, 1'b0);
    rd_cycle(16'h0000, 1'b0, d, v); check("R5 ram 0000", {7'b0, v, d}, 16'h0111);
    rd_cycle(16'h07FF, 1'b0, d, v); check("R5 ram 07FF", {7'b0, v, d}, 16'h01EE);
    rd_cycle(16'h0123, 1'b0, d, v); check("R5 ram 0123", {7'b0, v, d}, 16'h015A);
    rd_cycle(16'h0400, 1'b0, d, v); check("R8 ram read", {7'b0, v, d}, 16'h01C3);
  endtask

  task automatic t_rom_read;
    logic [7:0] d; logic v;
    logic [15:0] a [5];
    a[0] = 16'h3000; a[1] = 16'h3001; a[2] = 16'h3155; a[3] = 16'h32C0; a[4] = 16'h33FF;
    for (int k = 0; k < 5; k++) begin
      rd_cycle(a[k], 1'b0, d, v);
      check("R6 rom byte", {7'b0, v, d}, {7'b0, 1'b1, rom_exp(a[k])});
    end
  endtask

  task automatic t_rom_write;
    logic [7:0] d; logic v;
    wr_cycle(16'h3005, 8'h00, 1'b0);
    wr_cycle(16'h33FF, ~rom_exp(16'h33FF), 1'b0);
    rd_cycle(16'h3005, 1'b0, d, v); check("R7 rom 3005 kept", {8'b0, d}, {8'b0, rom_exp(16'h3005)});
    rd_cycle(16'h33FF, 1'b0, d, v); check("R7 rom 33FF kept", {8'b0, d}, {8'b0, rom_exp(16'h33FF)});
  endtask

  task automatic t_io_cycle;
    logic [7:0] d; logic v;
    wr_cycle(16'h0010, 8'h3C, 1'b0);
    wr_cycle(16'h0010, 8'hF0, 1'b1);
    rd_cycle(16'h0010, 1'b1, d, v); check("R9 io read idle", {7'b0, v, d}, 16'h0000);
    rd_cycle(16'h3010, 1'b1, d, v); check("R9 io read rom win", {7'b0, v, d}, 16'h0000);
    rd_cycle(16'h0010, 1'b0, d, v); check("R9 io write ignored", {7'b0, v, d}, 16'h013C);
  endtask

  task automatic t_bad_pair;
    logic [7:0] d; logic v;
    wr_cycle(16'h0020, 8'h77, 1'b0);
    @(negedge clk);
    addr = 16'h0020; wdata = 8'h88; rd_n = 1'b0; wr_n = 1'b0;
    #1;
    check("R2 both low no data", {7'b0, rvalid, rdata}, 16'h0000);
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    rd_cycle(16'h0020, 1'b0, d, v); check("R2 no write", {7'b0, v, d}, 16'h0177);
  endtask

  task automatic t_unmapped;
    logic [7:0] d; logic v;
    wr_cycle(16'h0800, 8'hAB, 1'b0);
    wr_cycle(16'h3400, 8'hCD, 1'b0);
    wr_cycle(16'hF800, 8'hEF, 1'b0);
    rd_cycle(16'h0000, 1'b0, d, v); check("R10 ram 0000 kept", {7'b0, v, d}, 16'h0111);
    rd_cycle(16'h0800, 1'b0, d, v); check("R10 read 0800", {7'b0, v, d}, 16'h0000);
    rd_cycle(16'h2FFF, 1'b0, d, v); check("R10 read 2FFF", {7'b0, v, d}, 16'h0000);
    rd_cycle(16'hFFFF, 1'b0, d, v); check("R10 read FFFF", {7'b0, v, d}, 16'h0000);
  endtask

  initial begin
    #(4 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_strobes();
    t_chip_sel();
    t_ram_rw();
    t_rom_read();
    t_rom_write();
    t_io_cycle();
    t_bad_pair();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule